// File: doc/BRIEF.md
# AUX Channel Transaction Front-End

This block sits between a software register window and the byte-level side of a display auxiliary channel. Software loads up to sixteen payload bytes into four write-data words, writes a command word naming the request code, the target address, the length and whether the request carries an address only, and then sets the go bit in the request/configuration register. The block serializes the request onto a byte stream with a ready handshake. It then waits for the sink's reply on a byte stream that has no backpressure, and files the outcome in a status word. When a read is acknowledged, the returned bytes appear in four read-data words.

The go bit stays set while a transaction is in flight and drops on its own when the transaction ends. It ends when the reply closes, when the reply timer runs out, or when software pulls the channel reset low. Software polls the go bit to learn that the transaction is complete. While a transaction is in flight, the command, payload and configuration registers are frozen, so the request frame cannot change under the serializer.

Top module: `aux_xact_ctrl`

## Requirements
- R1: After reset the command, data and status words read 0, the request/configuration word reads 0x1204 (minimum pulse field [13:9] = 9, timer enable bit 2 = 1, sync select bit 1 = 0, go bit 0 = 0), and the channel reset word reads 0x10. Registers written while idle read back as written: command bits [28:0] at 0x50, write data at 0x54/0x58/0x5C/0x60.
- R2: While the go bit is set, writes to the command word, the write-data words and the request/configuration word have no effect.
- R3: A request frame is sent one byte per accepted handshake. The first byte is {code[3:0], addr[19:16]}, then addr[15:8], then addr[7:0], then {4'h0, length-1}. For a write code (code bit 0 = 0), payload bytes 0 to length-1 follow in little-endian order from the write-data words. req_last marks the final byte, and a byte is held stable until req_ready is seen.
- R4: With command bit 28 (address only) set, only the three address bytes are sent. There is no length byte and no payload.
- R5: The first reply byte is stored as the reply code in status [11:4]. The ready count in status [16:12] counts that header byte plus every data byte accepted after it.
- R6: When a read is acknowledged (reply code 0x00), the data bytes are stored in order from read-data offset 0x64. Byte n goes to word n/4, bits [8*(n%4)+7 : 8*(n%4)].
- R7: When the reply code is not 0x00, the bytes after the header are ignored. The read-data words keep their values and the ready count stays 1.
- R8: When a write is acknowledged, a byte that follows the header is stored in the partial-write field, status [24:17], and the ready count becomes 2.
- R9: If the timer is enabled and no reply byte arrives within TIMEOUT_CYCLES cycles after the last request byte, status bit 0 is set and the go bit clears. With the timer disabled, the block waits for the reply without limit.
- R10: The go bit clears on its own when a transaction ends. No request byte is offered while the go bit is clear. Reply bytes that arrive when no reply is awaited change nothing.
- R11: Writing 0 to bit 4 of the channel reset word at 0x80 clears the go bit and returns the block to idle. While that bit is 0, setting the go bit has no effect. Writing 1 to the bit restores normal operation.
- R12: Starting a transaction clears the status word before the reply arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| req_valid | output | 1 | Request byte valid |
| req_data | output | 8 | Request byte |
| req_last | output | 1 | Final byte of the request frame |
| req_ready | input | 1 | Sink accepts the request byte |
| rep_valid | input | 1 | Reply byte valid |
| rep_data | input | 8 | Reply byte |
| rep_last | input | 1 | Final byte of the reply |

## Verification
The bench builds the block with TIMEOUT_CYCLES set to 40 and ADDR_W at its default of 12. The short timer lets both a timer expiry and a wait of several timer periods with the timer disabled fit into a few hundred cycles. The reference model predicts every request byte with a queue and checks each handshake against it, including a stretch in which req_ready toggles every cycle. It also covers acknowledged reads, a refused read, a partial write, an address-only request, late reply bytes and a channel reset issued while the block waits for a reply.

// File: rtl/auxfe_pkg.sv
package auxfe_pkg;

    localparam int unsigned AUX_MAX_BYTES = 16;
    localparam int unsigned AUX_WORDS     = AUX_MAX_BYTES / 4;
    localparam int unsigned CNT_W         = $clog2(AUX_MAX_BYTES + 2) + 0;

    // Register byte offsets
    localparam int unsigned OFS_CMD  = 32'h050;
    localparam int unsigned OFS_WDAT = 32'h054;
    localparam int unsigned OFS_RDAT = 32'h064;
    localparam int unsigned OFS_REQ  = 32'h074;
    localparam int unsigned OFS_STAT = 32'h078;
    localparam int unsigned OFS_RSTC = 32'h080;

    localparam logic [7:0] REPLY_ACK     = 8'h00;
    localparam logic [4:0] PULSE_DEFAULT = 5'd9;

    // Command word layout: [28] address only, [27:8] address, [7:4] length-1, [3:0] code
    typedef struct packed {
        logic        addr_only;
        logic [19:0] addr;
        logic [3:0]  len_m1;
        logic [3:0]  code;
    } cmd_t;

    typedef enum logic [1:0] {
        COL_IDLE = 2'd0,
        COL_WAIT = 2'd1,
        COL_RECV = 2'd2
    } col_state_e;

endpackage

// File: rtl/aux_req_ser.sv
module aux_req_ser
    import auxfe_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic                              abort,
    input  cmd_t                              cmd,
    input  logic [AUX_MAX_BYTES-1:0][7:0]     payload,
    input  logic                              req_ready,
    output logic                              req_valid,
    output logic [7:0]                        req_data,
    output logic                              req_last,
    output logic                              sent
);

    typedef struct packed {
        logic       active;
        logic [4:0] idx;
        logic [4:0] last_idx;
        logic       sent;
    } ser_t;

    ser_t q, d;
    logic [4:0] pay_off;

    always_comb begin
        d      = q;
        d.sent = 1'b0;
        if (abort) begin
            d.active = 1'b0;
        end else if (start && !q.active) begin
            d.active = 1'b1;
            d.idx    = '0;
            if (cmd.addr_only)
                d.last_idx = 5'd2;
            else if (!cmd.code[0])
                d.last_idx = 5'd4 + 5'(cmd.len_m1);
            else
                d.last_idx = 5'd3;
        end else if (q.active && req_ready) begin
            if (q.idx == q.last_idx) begin
                d.active = 1'b0;
                d.sent   = 1'b1;
            end else begin
                d.idx = q.idx + 5'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pay_off = q.idx - 5'd4;

    always_comb begin
        case (q.idx)
            5'd0:    req_data = {cmd.code, cmd.addr[19:16]};
            5'd1:    req_data = cmd.addr[15:8];
            5'd2:    req_data = cmd.addr[7:0];
            5'd3:    req_data = {4'h0, cmd.len_m1};
            default: req_data = payload[pay_off[3:0]];
        endcase
    end

    assign req_valid = q.active;
    assign req_last  = q.active && (q.idx == q.last_idx);
    assign sent      = q.sent;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !abort) |=> (req_valid && $stable(req_data))) else $error("hold"); // R3
    AST_SENT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        sent |-> ($past(req_last) && $past(req_ready) && !req_valid)) else $error("sent"); // R3

endmodule

// File: rtl/aux_rep_col.sv
module aux_rep_col
    import auxfe_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 400
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          arm,
    input  logic                          abort,
    input  logic                          is_read,
    input  logic                          timer_en,
    input  logic                          rep_valid,
    input  logic [7:0]                    rep_data,
    input  logic                          rep_last,
    output logic                          done,
    output logic                          timed_out,
    output logic [7:0]                    code,
    output logic [4:0]                    ready_cnt,
    output logic [7:0]                    partial,
    output logic [AUX_MAX_BYTES-1:0][7:0] rd_bytes
);

    localparam int unsigned TMR_W = $clog2(TIMEOUT_CYCLES + 1);

    typedef struct packed {
        col_state_e                    state;
        logic                          ack;
        logic [TMR_W-1:0]              tmr;
        logic                          done;
        logic                          tout;
        logic [7:0]                    code;
        logic [4:0]                    cnt;
        logic [7:0]                    part;
        logic [AUX_MAX_BYTES-1:0][7:0] rdb;
    } col_t;

    col_t q, d;
    logic [4:0] widx;

    assign widx = q.cnt - 5'd1;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (abort) begin
            d.state = COL_IDLE;
        end else begin
            if (clr) begin
                d.tout = 1'b0;
                d.code = '0;
                d.cnt  = '0;
                d.part = '0;
            end
            if (arm) begin
                d.state = COL_WAIT;
                d.tmr   = '0;
            end else begin
                case (q.state)
                    COL_WAIT: begin
                        if (rep_valid) begin
                            d.code = rep_data;
                            d.cnt  = 5'd1;
                            d.ack  = (rep_data == REPLY_ACK);
                            if (rep_last) begin
                                d.state = COL_IDLE;
                                d.done  = 1'b1;
                            end else begin
                                d.state = COL_RECV;
                            end
                        end else if (timer_en) begin
                            if (q.tmr == TMR_W'(TIMEOUT_CYCLES - 1)) begin
                                d.tout  = 1'b1;
                                d.done  = 1'b1;
                                d.state = COL_IDLE;
                            end else begin
                                d.tmr = q.tmr + 1'b1;
                            end
                        end
                    end
                    COL_RECV: begin
                        if (rep_valid) begin
                            if (q.ack) begin
                                if (q.cnt != 5'd31)
                                    d.cnt = q.cnt + 5'd1;
                                if (is_read) begin
                                    if (q.cnt <= 5'(AUX_MAX_BYTES))
                                        d.rdb[widx[3:0]] = rep_data;
                                end else begin
                                    d.part = rep_data;
                                end
                            end
                            if (rep_last) begin
                                d.state = COL_IDLE;
                                d.done  = 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done      = q.done;
    assign timed_out = q.tout;
    assign code      = q.code;
    assign ready_cnt = q.cnt;
    assign partial   = q.part;
    assign rd_bytes  = q.rdb;

    AST_NACK_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == COL_RECV && !q.ack) |=> $stable(q.cnt)) else $error("nack"); // R7
    AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.tout) |-> (q.done && q.state == COL_IDLE)) else $error("tout"); // R9
    AST_TIMER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == COL_WAIT && !timer_en && !clr) |=> !q.tout) else $error("timer off"); // R9

endmodule

// File: rtl/aux_xact_ctrl.sv
module aux_xact_ctrl
    import auxfe_pkg::*;
#(
    parameter int unsigned ADDR_W         = 12,
    parameter int unsigned TIMEOUT_CYCLES = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              req_valid,
    output logic [7:0]        req_data,
    output logic              req_last,
    input  logic              req_ready,
    input  logic              rep_valid,
    input  logic [7:0]        rep_data,
    input  logic              rep_last
);

    typedef struct packed {
        cmd_t                          cmd;
        logic [AUX_WORDS-1:0][31:0]    wdat;
        logic                          sync_sel;
        logic                          tmr_en;
        logic [4:0]                    pulse;
        logic                          aux_run;
        logic                          busy;
        logic                          start;
    } top_t;

    top_t q, d;

    logic                          abort;
    logic                          sent;
    logic                          col_done;
    logic                          col_tout;
    logic [7:0]                    col_code;
    logic [4:0]                    col_cnt;
    logic [7:0]                    col_part;
    logic [AUX_MAX_BYTES-1:0][7:0] col_rdb;
    logic [AUX_WORDS-1:0][31:0]    rd_words;
    logic [AUX_MAX_BYTES-1:0][7:0] pay_bytes;

    assign abort     = !q.aux_run;
    assign rd_words  = col_rdb;
    assign pay_bytes = q.wdat;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (col_done || abort)
            d.busy = 1'b0;
        if (reg_wr) begin
            if (reg_addr == ADDR_W'(OFS_CMD) && !q.busy)
                d.cmd = cmd_t'(reg_wdata[28:0]);
            for (int k = 0; k < int'(AUX_WORDS); k++) begin
                if (reg_addr == ADDR_W'(OFS_WDAT + 4 * k) && !q.busy)
                    d.wdat[k] = reg_wdata;
            end
            if (reg_addr == ADDR_W'(OFS_REQ) && !q.busy) begin
                d.sync_sel = reg_wdata[1];
                d.tmr_en   = reg_wdata[2];
                d.pulse    = reg_wdata[13:9];
                if (reg_wdata[0] && q.aux_run) begin
                    d.busy  = 1'b1;
                    d.start = 1'b1;
                end
            end
            if (reg_addr == ADDR_W'(OFS_RSTC))
                d.aux_run = reg_wdata[4];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.tmr_en  <= 1'b1;
            q.pulse   <= PULSE_DEFAULT;
            q.aux_run <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_CMD))
            reg_rdata = {3'b0, q.cmd};
        for (int k = 0; k < int'(AUX_WORDS); k++) begin
            if (reg_addr == ADDR_W'(OFS_WDAT + 4 * k))
                reg_rdata = q.wdat[k];
            if (reg_addr == ADDR_W'(OFS_RDAT + 4 * k))
                reg_rdata = rd_words[k];
        end
        if (reg_addr == ADDR_W'(OFS_REQ))
            reg_rdata = {18'b0, q.pulse, 6'b0, q.tmr_en, q.sync_sel, q.busy};
        if (reg_addr == ADDR_W'(OFS_STAT))
            reg_rdata = {7'b0, col_part, col_cnt, col_code, 3'b0, col_tout};
        if (reg_addr == ADDR_W'(OFS_RSTC))
            reg_rdata = {27'b0, q.aux_run, 4'b0};
    end

    aux_req_ser u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (q.start),
        .abort     (abort),
        .cmd       (q.cmd),
        .payload   (pay_bytes),
        .req_ready (req_ready),
        .req_valid (req_valid),
        .req_data  (req_data),
        .req_last  (req_last),
        .sent      (sent)
    );

    aux_rep_col #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_col (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (q.start),
        .arm       (sent),
        .abort     (abort),
        .is_read   (q.cmd.code[0]),
        .timer_en  (q.tmr_en),
        .rep_valid (rep_valid),
        .rep_data  (rep_data),
        .rep_last  (rep_last),
        .done      (col_done),
        .timed_out (col_tout),
        .code      (col_code),
        .ready_cnt (col_cnt),
        .partial   (col_part),
        .rd_bytes  (col_rdb)
    );

    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |=> ($stable(q.cmd) && $stable(q.wdat) && $stable(q.tmr_en))) else $error("frozen"); // R2
    AST_DONE_CLEARS_GO: assert property (@(posedge clk) disable iff (!rst_n)
        col_done |=> !q.busy) else $error("done"); // R10
    AST_NO_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> !req_valid) else $error("idle req"); // R10
    AST_AUX_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !q.aux_run |=> (!q.busy && !req_valid)) else $error("aux rst"); // R11

endmodule

// File: tb/aux_xact_ctrl_tb.sv
`timescale 1ns/1ps
module aux_xact_ctrl_tb;

    localparam int TMO = 40;
    localparam logic [11:0] A_CMD = 12'h050, A_WD = 12'h054, A_RD = 12'h064,
                            A_REQ = 12'h074, A_ST = 12'h078, A_RST = 12'h080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid, req_last;
    logic [7:0]  req_data;
    logic        req_ready = 1'b1;
    logic        rep_valid = 1'b0;
    logic [7:0]  rep_data = '0;
    logic        rep_last = 1'b0;

    int checks = 0;
    int errors = 0;
    bit ready_mode = 1'b1;
    logic [31:0] cfg_word = 32'h1204;
    byte unsigned expq[$];
    byte unsigned pl[16];
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    aux_xact_ctrl #(.ADDR_W(12), .TIMEOUT_CYCLES(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_data(req_data), .req_last(req_last), .req_ready(req_ready),
        .rep_valid(rep_valid), .rep_data(rep_data), .rep_last(rep_last)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] stat(input bit to, input logic [7:0] c,
                                         input logic [4:0] n, input logic [7:0] p);
        return {7'b0, p, n, c, 3'b0, to};
    endfunction

    // Sink model: toggling or steady ready
    always @(posedge clk) begin
        #1;
        if (ready_mode) req_ready <= 1'b1;
        else            req_ready <= ~req_ready;
    end

    // Reference comparison on every clock
    always @(negedge clk) begin
        if (rst_n && req_valid) begin
            if (expq.size() == 0) begin
                chk("R10 request byte offered with none expected", 32'(req_data), 32'hFFFF_FFFF);
            end else if (req_ready) begin
                byte unsigned e;
                e = expq.pop_front();
                chk("R3 request byte", 32'(req_data), 32'(e));
                chk("R3 last flag", 32'(req_last), 32'(expq.size() == 0));
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic launch(input logic [3:0] code, input logic [19:0] addr,
                          input int len, input bit aonly);
        logic [3:0] lm1;
        lm1 = 4'(len - 1);
        for (int k = 0; k < 4; k++)
            wr(A_WD + 12'(4 * k), {pl[4*k+3], pl[4*k+2], pl[4*k+1], pl[4*k]});
        wr(A_CMD, {3'b0, aonly, addr, lm1, code});
        expq.push_back({code, addr[19:16]});
        expq.push_back(addr[15:8]);
        expq.push_back(addr[7:0]);
        if (!aonly) begin
            expq.push_back({4'h0, lm1});
            if (!code[0])
                for (int i = 0; i < len; i++) expq.push_back(pl[i]);
        end
        wr(A_REQ, cfg_word | 32'h1);
    endtask

    task automatic wait_sent();
        for (int i = 0; i < 200 && expq.size() != 0; i++) @(negedge clk);
        chk("R3 frame completed", 32'(expq.size()), 32'd0);
        repeat (2) @(negedge clk);
    endtask

    task automatic reply(input byte unsigned r[$]);
        for (int i = 0; i < r.size(); i++) begin
            @(negedge clk);
            rep_valid = 1'b1; rep_data = r[i]; rep_last = (i == r.size() - 1);
        end
        @(negedge clk);
        rep_valid = 1'b0; rep_last = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] v;
        v = 32'h1;
        for (int i = 0; i < 100 && v[0]; i++) rd(A_REQ, v);
        chk(tag, 32'(v[0]), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CMD, rv);  chk("R1 reset command", rv, 32'h0);
        rd(A_REQ, rv);  chk("R1 reset request/config", rv, 32'h1204);
        rd(A_ST, rv);   chk("R1 reset status", rv, 32'h0);
        rd(A_RST, rv);  chk("R1 reset channel reset word", rv, 32'h10);
        rd(A_RD, rv);   chk("R1 reset read data", rv, 32'h0);
        wr(A_CMD, 32'h1ABC_DEF5); rd(A_CMD, rv); chk("R1 command readback", rv, 32'h1ABC_DEF5);
        wr(A_WD + 12'd8, 32'hCAFE_0123); rd(A_WD + 12'd8, rv); chk("R1 data readback", rv, 32'hCAFE_0123);

        // R3 native write with toggling ready
        ready_mode = 1'b0;
        foreach (pl[i]) pl[i] = 8'(8'h11 * (i + 1));
        launch(4'h8, 20'h12345, 5, 1'b0);
        wait_sent();
        ready_mode = 1'b1;
        reply('{8'h00});
        wait_idle("R10 go clears after write");
        rd(A_ST, rv); chk("R5 write ack status", rv, stat(0, 8'h00, 5'd1, 8'h00));

        // R5 R6 acknowledged read
        launch(4'h9, 20'h00100, 6, 1'b0);
        wait_sent();
        reply('{8'h00, 8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5});
        wait_idle("R10 go clears after read");
        rd(A_ST, rv);          chk("R5 read ready count", rv, stat(0, 8'h00, 5'd7, 8'h00));
        rd(A_RD, rv);          chk("R6 read word 0", rv, 32'hA3A2_A1A0);
        rd(A_RD + 12'd4, rv);  chk("R6 read word 1", rv, 32'h0000_A5A4);

        // R7 refused read
        launch(4'h9, 20'h00100, 2, 1'b0);
        wait_sent();
        reply('{8'h10, 8'hEE, 8'hEF});
        wait_idle("R10 go clears after refusal");
        rd(A_ST, rv); chk("R7 refused status", rv, stat(0, 8'h10, 5'd1, 8'h00));
        rd(A_RD, rv); chk("R7 read data kept", rv, 32'hA3A2_A1A0);

        // R12 R8 partial I2C write
        pl[0] = 8'h5A; pl[1] = 8'h5B; pl[2] = 8'h5C;
        launch(4'h4, 20'h00050, 3, 1'b0);
        rd(A_ST, rv); chk("R12 status cleared at start", rv, 32'h0);
        wait_sent();
        reply('{8'h00, 8'h02});
        wait_idle("R10 go clears after partial write");
        rd(A_ST, rv); chk("R8 partial write status", rv, stat(0, 8'h00, 5'd2, 8'h02));

        // R4 address-only request
        launch(4'h5, 20'h00050, 1, 1'b1);
        wait_sent();
        reply('{8'h00});
        wait_idle("R10 go clears after address-only");
        rd(A_ST, rv); chk("R4 address-only status", rv, stat(0, 8'h00, 5'd1, 8'h00));

        // R2 writes ignored while busy
        pl[0] = 8'h01; pl[1] = 8'h02; pl[2] = 8'h03; pl[3] = 8'h04;
        launch(4'h9, 20'h00200, 1, 1'b0);
        wait_sent();
        wr(A_CMD, 32'h0000_FFFF);
        wr(A_WD, 32'hDEAD_BEEF);
        wr(A_REQ, 32'h0);
        reply('{8'h00, 8'h77});
        wait_idle("R10 go clears after busy test");
        rd(A_CMD, rv); chk("R2 command unchanged", rv, 32'h0002_0009);
        rd(A_WD, rv);  chk("R2 data unchanged", rv, 32'h0403_0201);
        rd(A_REQ, rv); chk("R2 config unchanged", rv, 32'h1204);
        rd(A_RD, rv);  chk("R6 single byte read", rv[7:0], 32'h77);

        // R9 timeout, R10 late reply ignored
        launch(4'h9, 20'h00300, 1, 1'b0);
        wait_sent();
        repeat (10) @(negedge clk);
        rd(A_REQ, rv); chk("R9 still waiting before timeout", 32'(rv[0]), 32'd1);
        repeat (TMO + 10) @(negedge clk);
        rd(A_REQ, rv); chk("R9 go cleared by timeout", 32'(rv[0]), 32'd0);
        rd(A_ST, rv);  chk("R9 timeout status", rv, stat(1, 8'h00, 5'd0, 8'h00));
        reply('{8'h00, 8'h99});
        rd(A_ST, rv);  chk("R10 late reply ignored status", rv, stat(1, 8'h00, 5'd0, 8'h00));
        rd(A_RD, rv);  chk("R10 late reply ignored data", rv[7:0], 32'h77);

        // R9 timer disabled
        cfg_word = 32'h1200;
        wr(A_REQ, cfg_word);
        launch(4'h9, 20'h00300, 1, 1'b0);
        wait_sent();
        repeat (3 * TMO) @(negedge clk);
        rd(A_REQ, rv); chk("R9 no timeout when disabled", 32'(rv[0]), 32'd1);
        reply('{8'h00, 8'h42});
        wait_idle("R10 go clears after long wait");
        rd(A_ST, rv); chk("R9 status after long wait", rv, stat(0, 8'h00, 5'd2, 8'h00));
        rd(A_RD, rv); chk("R6 data after long wait", rv[7:0], 32'h42);
        cfg_word = 32'h1204;
        wr(A_REQ, cfg_word);

        // R11 channel reset
        launch(4'h9, 20'h00400, 1, 1'b0);
        wait_sent();
        wr(A_RST, 32'h0);
        rd(A_REQ, rv); chk("R11 go cleared by channel reset", 32'(rv[0]), 32'd0);
        wr(A_REQ, cfg_word | 32'h1);
        repeat (5) @(negedge clk);
        rd(A_REQ, rv); chk("R11 go ignored in channel reset", 32'(rv[0]), 32'd0);
        wr(A_RST, 32'h10);
        pl[0] = 8'hC3;
        launch(4'h8, 20'h00400, 1, 1'b0);
        wait_sent();
        reply('{8'h00});
        wait_idle("R11 go clears after release");
        rd(A_ST, rv); chk("R11 operation after release", rv, stat(0, 8'h00, 5'd1, 8'h00));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule